// File: doc/BRIEF.md
# DAC Core Control and Reset Register Block

This block is the software-facing control point of a DAC datapath core. It sits on a simple 32-bit register bus that is addressed in words. It holds a reset register, a channel synchronisation control, a channel-grouping control, a read-only build configuration word and a read-only status word. From these registers it drives the reset of the clock-generation unit, the reset of the core datapath and a clock-enable line. It also drives one synchronisation strobe per channel and a mode line that the channel datapaths decode.

Software brings the core up in a fixed order. First it releases the clock-unit reset. It then polls the lock flag in the status word. Finally it sets the core and clock-unit reset bits together. The block enforces this order in hardware. The datapath reset output stays asserted until the clock unit is out of reset and the synchronised lock input is high, whatever software writes. A write of 1 to the synchronisation bit produces exactly one strobe cycle on every channel. The bit then clears itself.

Top module: `dac_ctrl_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, every writable bit returns to 0. Afterwards the reset register, the sync bit and the mode bit read 0, and `clk_unit_rst_n_o`, `core_rst_n_o`, `core_clk_en_n_o`, `chan_sync_o` and `indep_mode_o` are all 0.
- R2: The reset register is at word address 0x10 (byte 0x40). Bits 2..0 are writable and read back, and higher bits read 0. Bit 1 drives `clk_unit_rst_n_o` and bit 2 drives `core_clk_en_n_o`, each changing after the write edge.
- R3: `core_rst_n_o` is 1 only while reset bits 0 and 1 are both 1 and the synchronised lock is 1. Lock passes through a SYNC_STAGES-flop synchroniser (default 2), so `core_rst_n_o` follows a change of `clk_lock_i` two clock edges later.
- R4: The status word at word address 0x1D (byte 0x74) returns the synchronised lock in bit 17. All other bits read 0.
- R5: A write with bit 0 = 1 to word address 0x11 (byte 0x44) raises every bit of `chan_sync_o` for exactly the one cycle after the write edge. A write with bit 0 = 0 raises none.
- R6: The sync bit clears itself. A read of word 0x11 issued two or more cycles after the write returns 0.
- R7: Word address 0x12 (byte 0x48) holds the independent-channel bit in bit 4. It drives `indep_mode_o` and reads back in bit 4. Its reset value is 0, which selects the shared-stream grouping.
- R8: Word address 0x03 (byte 0x0C) is read-only. Its bit 6 reads 1 when TONE_GEN_PRESENT is 0 and 0 otherwise. Writes to it leave its value unchanged.
- R9: A read of any unmapped word address, including those up to 0x200 (byte 0x800) and beyond, returns 0. A write to an unmapped address changes no register and no output.
- R10: `bus_rdata_o` is registered. It presents the addressed word in the cycle after the edge that samples `bus_rd_en_i` and holds that value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en_i | input | 1 | Write strobe, one word per cycle |
| bus_rd_en_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| clk_lock_i | input | 1 | Lock flag from the clock-generation unit (asynchronous) |
| clk_unit_rst_n_o | output | 1 | Active-low reset to the clock-generation unit |
| core_rst_n_o | output | 1 | Gated active-low reset to the core datapath |
| core_clk_en_n_o | output | 1 | Active-low clock enable for the datapath |
| chan_sync_o | output | N_CHAN | One-cycle settings-update strobe, one bit per channel |
| indep_mode_o | output | 1 | 1 = independent channels, 0 = shared data stream |

## Verification
The register map is exercised with all-ones and sparse patterns. All-ones shows which bits each register implements. The sparse patterns show that stored bits do not bleed into neighbouring bits. Read-only and unmapped addresses get the same all-ones writes, with a mapped register read back afterwards, to show that nothing is aliased. The reset gating is driven through each combination of the clock-unit bit, the core bit and the lock input, with lock toggled at known edges, to separate a correct synchroniser depth from a missing or extra stage. Sync writes with bit 0 set and with bit 0 clear separate a real strobe from one raised by any access to the address.

// File: rtl/dac_ctrl_pkg.sv
// Package: dac_ctrl_pkg
// Shared word addresses, bit positions and the decode select type for the
// DAC core control register block. Addresses are word indices (byte >> 2).
package dac_ctrl_pkg;

    localparam int WA_CONFIG = 'h003;   // byte 0x0C
    localparam int WA_RESET  = 'h010;   // byte 0x40
    localparam int WA_CTRL1  = 'h011;   // byte 0x44
    localparam int WA_CTRL2  = 'h012;   // byte 0x48
    localparam int WA_STATUS = 'h01D;   // byte 0x74
    localparam int WA_LAST   = 'h200;   // byte 0x800, top of the window

    localparam int RB_CORE_N   = 0;     // reset register: core reset, active low
    localparam int RB_CLKU_N   = 1;     // reset register: clock-unit reset, active low
    localparam int RB_CE_N     = 2;     // reset register: clock enable, active low
    localparam int RST_BITS    = 3;
    localparam int SYNC_BIT    = 0;
    localparam int MODE_BIT    = 4;
    localparam int NOTONE_BIT  = 6;
    localparam int LOCK_BIT    = 17;

    typedef struct packed {
        logic config_w;
        logic reset_w;
        logic ctrl1_w;
        logic ctrl2_w;
        logic status_w;
    } reg_sel_t;

endpackage

// File: rtl/dac_ctrl_decode.sv
// Module: dac_ctrl_decode
// Turns a word address into one select line per mapped register.
// Assumes: addresses are word indices; anything not listed in the package
// is unmapped and yields no select.
module dac_ctrl_decode
    import dac_ctrl_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o,
    output logic              hit_o
);

    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(WA_CONFIG);
    localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(WA_RESET);
    localparam logic [ADDR_W-1:0] A_CT1  = ADDR_W'(WA_CTRL1);
    localparam logic [ADDR_W-1:0] A_CT2  = ADDR_W'(WA_CTRL2);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(WA_STATUS);

    // Compare the address against each mapped register.
    always_comb begin
        sel_o.config_w = (addr_i == A_CFG);
        sel_o.reset_w  = (addr_i == A_RST);
        sel_o.ctrl1_w  = (addr_i == A_CT1);
        sel_o.ctrl2_w  = (addr_i == A_CT2);
        sel_o.status_w = (addr_i == A_STAT);
        hit_o          = |sel_o;
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o)); // R9

endmodule

// File: rtl/dac_ctrl_reset_gate.sv
// Module: dac_ctrl_reset_gate
// Synchronises the clock-unit lock flag and derives the reset outputs from
// the software reset bits. The core reset is released only while the clock
// unit is out of reset, software asks for release and lock is seen.
// Assumes: lock_i is asynchronous to clk; reset bits come from registers.
module dac_ctrl_reset_gate
    import dac_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lock_i,
    input  logic [RST_BITS-1:0] rst_bits_i,
    output logic                lock_sync_o,
    output logic                clk_unit_rst_n_o,
    output logic                core_rst_n_o,
    output logic                ce_n_o
);

    logic [SYNC_STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                // Capture the raw lock flag.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= lock_i;
                end
            end else begin : g_next
                // Pass the lock flag one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    // Drive the reset outputs from the register bits and the synced lock.
    always_comb begin
        lock_sync_o      = chain_q[SYNC_STAGES-1];
        clk_unit_rst_n_o = rst_bits_i[RB_CLKU_N];
        ce_n_o           = rst_bits_i[RB_CE_N];
        core_rst_n_o     = rst_bits_i[RB_CORE_N] & rst_bits_i[RB_CLKU_N]
                         & chain_q[SYNC_STAGES-1];
    end

    AST_CORE_AFTER_CLKU: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_n_o |-> clk_unit_rst_n_o); // R3
    AST_CORE_DROPS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_sync_o) |-> !core_rst_n_o); // R3

endmodule

// File: rtl/dac_ctrl_sync_pulse.sv
// Module: dac_ctrl_sync_pulse
// Holds the self-clearing sync request and broadcasts it as a strobe to all
// channels for the single cycle after the request is written.
// Assumes: fire_i is a qualified write of a 1 to the sync bit.
module dac_ctrl_sync_pulse #(
    parameter int N_CHAN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    output logic              req_o,
    output logic [N_CHAN-1:0] pulse_o
);

    logic req_q;

    // Set on a qualified write, clear on every other cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= fire_i;
    end

    assign req_o = req_q;

    generate
        for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
            // Fan the request out to channel c.
            assign pulse_o[c] = req_q;
        end
    endgenerate

    AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o[0] |-> $past(fire_i)); // R5

endmodule

// File: rtl/dac_ctrl_regs.sv
// Module: dac_ctrl_regs (top)
// Register file for the DAC core control block: reset register, sync
// control, channel-mode control, read-only configuration and status.
// Assumes: one access per cycle; write and read strobes are not both used
// on the same cycle by the bus master (a write then wins nothing: both act).
module dac_ctrl_regs
    import dac_ctrl_pkg::*;
#(
    parameter int N_CHAN           = 4,
    parameter int ADDR_W           = 10,
    parameter int SYNC_STAGES      = 2,
    parameter bit TONE_GEN_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en_i,
    input  logic              bus_rd_en_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    input  logic              clk_lock_i,
    output logic              clk_unit_rst_n_o,
    output logic              core_rst_n_o,
    output logic              core_clk_en_n_o,
    output logic [N_CHAN-1:0] chan_sync_o,
    output logic              indep_mode_o
);

    localparam logic [31:0] CONFIG_WORD = 32'(!TONE_GEN_PRESENT) << NOTONE_BIT;

    reg_sel_t            sel;
    logic                hit;
    logic [RST_BITS-1:0] rst_bits_q;
    logic                mode_q;
    logic                sync_req;
    logic                lock_sync;
    logic                sync_fire;
    logic [31:0]         rd_word;
    logic [31:0]         rdata_q;
    logic                unused_wdata;

    assign unused_wdata = ^{bus_wdata_i[31:5], bus_wdata_i[3]};

    dac_ctrl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (bus_addr_i),
        .sel_o  (sel),
        .hit_o  (hit)
    );

    // Hold the software reset bits and the channel-mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_bits_q <= '0;
            mode_q     <= 1'b0;
        end else if (bus_wr_en_i) begin
            if (sel.reset_w) rst_bits_q <= bus_wdata_i[RST_BITS-1:0];
            if (sel.ctrl2_w) mode_q     <= bus_wdata_i[MODE_BIT];
        end
    end

    assign sync_fire = bus_wr_en_i & sel.ctrl1_w & bus_wdata_i[SYNC_BIT];

    dac_ctrl_sync_pulse #(.N_CHAN(N_CHAN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (sync_fire),
        .req_o   (sync_req),
        .pulse_o (chan_sync_o)
    );

    dac_ctrl_reset_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk              (clk),
        .rst_n            (rst_n),
        .lock_i           (clk_lock_i),
        .rst_bits_i       (rst_bits_q),
        .lock_sync_o      (lock_sync),
        .clk_unit_rst_n_o (clk_unit_rst_n_o),
        .core_rst_n_o     (core_rst_n_o),
        .ce_n_o           (core_clk_en_n_o)
    );

    // Select the word addressed by the current read.
    always_comb begin
        rd_word = '0;
        if (sel.config_w) rd_word = CONFIG_WORD;
        if (sel.reset_w)  rd_word[RST_BITS-1:0] = rst_bits_q;
        if (sel.ctrl1_w)  rd_word[SYNC_BIT] = sync_req;
        if (sel.ctrl2_w)  rd_word[MODE_BIT] = mode_q;
        if (sel.status_w) rd_word[LOCK_BIT] = lock_sync;
    end

    // Register the read data; hold it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)           rdata_q <= '0;
        else if (bus_rd_en_i) rdata_q <= rd_word;
    end

    assign bus_rdata_o  = rdata_q;
    assign indep_mode_o = mode_q;

    AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en_i && !hit) |=> ($stable(rst_bits_q) && $stable(mode_q))); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en_i |=> $stable(bus_rdata_o)); // R10
    AST_STATUS_ONLY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en_i && sel.status_w) |=> ((bus_rdata_o & ~(32'd1 << LOCK_BIT)) == 32'd0)); // R4
    AST_CONFIG_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en_i && sel.config_w) |=> (bus_rdata_o == CONFIG_WORD)); // R8

endmodule

// File: tb/dac_ctrl_regs_tb_top.sv
module dac_ctrl_regs_tb_top;

    localparam int N_CHAN = 4;
    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              lock = 1'b0;
    logic              clku_n, core_n, ce_n, mode;
    logic [N_CHAN-1:0] sync;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;   // 250 MHz

    dac_ctrl_regs #(
        .N_CHAN(N_CHAN), .ADDR_W(ADDR_W), .SYNC_STAGES(2), .TONE_GEN_PRESENT(1'b0)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_en_i(wr_en), .bus_rd_en_i(rd_en), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .clk_lock_i(lock),
        .clk_unit_rst_n_o(clku_n), .core_rst_n_o(core_n),
        .core_clk_en_n_o(ce_n), .chan_sync_o(sync), .indep_mode_o(mode)
    );

    // Vector: op(2) 1=write 2=read | req(4) | addr(10) | data(32) | expected(32)
    localparam int NV = 18;
    localparam logic [79:0] VEC [0:NV-1] = '{
        {2'd1, 4'd2, 10'h010, 32'hFFFF_FFFF, 32'h0},
        {2'd2, 4'd2, 10'h010, 32'h0,         32'h0000_0007},
        {2'd1, 4'd2, 10'h010, 32'h0000_0005, 32'h0},
        {2'd2, 4'd2, 10'h010, 32'h0,         32'h0000_0005},
        {2'd1, 4'd7, 10'h012, 32'hFFFF_FFFF, 32'h0},
        {2'd2, 4'd7, 10'h012, 32'h0,         32'h0000_0010},
        {2'd1, 4'd7, 10'h012, 32'hFFFF_FFEF, 32'h0},
        {2'd2, 4'd7, 10'h012, 32'h0,         32'h0000_0000},
        {2'd2, 4'd8, 10'h003, 32'h0,         32'h0000_0040},
        {2'd1, 4'd8, 10'h003, 32'h0,         32'h0},
        {2'd2, 4'd8, 10'h003, 32'h0,         32'h0000_0040},
        {2'd1, 4'd9, 10'h020, 32'hFFFF_FFFF, 32'h0},
        {2'd2, 4'd9, 10'h010, 32'h0,         32'h0000_0005},
        {2'd2, 4'd9, 10'h200, 32'h0,         32'h0},
        {2'd2, 4'd9, 10'h3FF, 32'h0,         32'h0},
        {2'd2, 4'd4, 10'h01D, 32'h0,         32'h0},
        {2'd1, 4'd2, 10'h010, 32'h0,         32'h0},
        {2'd2, 4'd2, 10'h010, 32'h0,         32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 outputs", {27'd0, clku_n, core_n, ce_n, mode, |sync}, 32'd0);
        bus_read(10'h010, rd); chk("R1 reset reg", rd, 32'd0);

        // Vector table: R2 R4 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][79:78] == 2'd1) begin
                bus_write(VEC[i][73:64], VEC[i][63:32]);
            end else begin
                bus_read(VEC[i][73:64], rd);
                checks++;
                if (rd !== VEC[i][31:0]) begin
                    failures++;
                    $display("FAIL R%0d vec %0d actual=%h expected=%h",
                             VEC[i][77:74], i, rd, VEC[i][31:0]);
                end
            end
        end

        // R10: read data holds while no read is issued
        bus_read(10'h003, rd);
        repeat (4) @(negedge clk);
        chk("R10 hold", rdata, 32'h40);

        // R7: mode bit drives the output
        bus_write(10'h012, 32'h10);
        chk("R7 indep_mode_o", {31'd0, mode}, 32'd1);
        // R9: unmapped write leaves outputs alone
        bus_write(10'h013, 32'h0);
        chk("R9 mode after unmapped write", {31'd0, mode}, 32'd1);

        // R5/R6: sync strobe
        @(negedge clk);
        wr_en = 1'b1; addr = 10'h011; wdata = 32'h1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        chk("R5 strobe high", 32'(sync), 32'hF);
        @(negedge clk);
        chk("R5 strobe one cycle", 32'(sync), 32'h0);
        bus_read(10'h011, rd); chk("R6 self-clear", rd, 32'd0);
        @(negedge clk);
        wr_en = 1'b1; addr = 10'h011; wdata = 32'hFFFF_FFFE;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        chk("R5 no strobe on bit0=0", 32'(sync), 32'h0);

        // R2/R3: reset gating
        bus_write(10'h010, 32'h2);
        chk("R2 clock unit released", {31'd0, clku_n}, 32'd1);
        chk("R3 core held, bit0 clear", {31'd0, core_n}, 32'd0);
        bus_write(10'h010, 32'h3);
        chk("R3 core held without lock", {31'd0, core_n}, 32'd0);
        lock = 1'b1;
        @(negedge clk);
        chk("R3 core held one edge after lock", {31'd0, core_n}, 32'd0);
        @(negedge clk);
        chk("R3 core released two edges after lock", {31'd0, core_n}, 32'd1);
        bus_read(10'h01D, rd); chk("R4 status lock", rd, 32'h0002_0000);
        bus_write(10'h010, 32'h1);
        chk("R3 core held, clock unit in reset", {30'd0, clku_n, core_n}, 32'd0);
        bus_write(10'h010, 32'h7);
        chk("R2 clock enable bit", {30'd0, ce_n, core_n}, 32'd3);
        lock = 1'b0;
        @(negedge clk);
        chk("R3 core still out one edge after unlock", {31'd0, core_n}, 32'd1);
        @(negedge clk);
        chk("R3 core reset on unlock", {31'd0, core_n}, 32'd0);

        // R1: reset returns all state to zero
        lock = 1'b1;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 after reset", {27'd0, clku_n, core_n, ce_n, mode, |sync}, 32'd0);
        bus_read(10'h012, rd); chk("R1 mode reg", rd, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule